// File: doc/BRIEF.md
# I2C Byte Shifter with Bus-Level Capture

This block is the eight-bit data shifter that sits between the host and the SDA line of an I2C controller, and it serves all four I2C modes. The host writes a byte in parallel. On each falling SCL strobe from the bus timing logic, the shifter presents its most significant bit to the SDA driver. On each rising SCL strobe, it shifts left and takes the SDA level seen on the bus into bit 0. After eight rising strobes it raises a byte-complete flag, and the host reads the byte back in parallel.

The shifter always captures the real bus level, including while it transmits. For this reason the register holds whatever byte the wire carried last. When the transmitter sees its own released (high) bit pulled low, it marks arbitration as lost and stops driving. It keeps shifting in the bus level, so the byte it holds is the correct received byte when the controller switches to slave receiver.

The bus timing logic does not strobe the shifter during acknowledge clocks. Acknowledge generation, address matching and clock generation are handled elsewhere.

Top module: `i2c_byte_shifter`

## Requirements
- R1: During and after reset, rd_data is 0x00, sda_out is 1, byte_done is 0 and arb_lost is 0.
- R2: A load pulse is accepted when no bits have been sampled since the last START, accepted load or byte completion, and scl_rise is low in that cycle. An accepted load puts load_data on rd_data in the next cycle and clears byte_done and arb_lost.
- R3: sda_out changes only on a cycle with scl_fall. It then takes the register's current bit 7, or 1 when arb_lost is set.
- R4: On scl_rise the register shifts toward bit 7 and sda_in enters bit 0. The first bit sent is bit 7, and the first bit received ends up in bit 7 after eight rises.
- R5: byte_done is set in the cycle after the eighth rise counted since START or an accepted load. The next rise, a START or an accepted load clears it.
- R6: A load pulse while a byte is partly shifted leaves rd_data unchanged.
- R7: start clears the bit count, byte_done and arb_lost, and leaves rd_data unchanged.
- R8: If tx_mode is 1 and a rise samples sda_in at 0 while sda_out is 1, arb_lost is set from the next cycle. From then on every scl_fall drives sda_out to 1.
- R9: The register holds the byte that appeared on the bus, not the byte that was loaded, even while transmitting and after arbitration is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load | input | 1 | Host parallel write strobe |
| load_data | input | 8 | Byte to load |
| rd_data | output | 8 | Current register contents |
| start | input | 1 | START or repeated START detected |
| scl_fall | input | 1 | One-cycle strobe, SCL went low |
| scl_rise | input | 1 | One-cycle strobe, SCL went high |
| sda_in | input | 1 | Synchronised SDA level |
| tx_mode | input | 1 | 1 while this side transmits, enables arbitration check |
| sda_out | output | 1 | Bit to drive, 1 means released |
| byte_done | output | 1 | Eight bits sampled |
| arb_lost | output | 1 | Arbitration lost in the current byte |

## Verification
A wrong bit count appears at byte_done: the flag rises one rise too early or too late, or never rises. A bad shift shows up in rd_data in the cycle right after the faulty rise, because the register is visible at all times. A stale arbitration flag or output bit shows on sda_out at the very next scl_fall, and the cycle-by-cycle model catches it there rather than at the end of the byte.

// File: rtl/i2c_byte_shifter.sv
module i2c_byte_shifter #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [WIDTH-1:0] load_data,
  output logic [WIDTH-1:0] rd_data,
  input  logic             start,
  input  logic             scl_fall,
  input  logic             scl_rise,
  input  logic             sda_in,
  input  logic             tx_mode,
  output logic             sda_out,
  output logic             byte_done,
  output logic             arb_lost
);
  localparam int CW = $clog2(WIDTH);
  localparam logic [CW-1:0] LAST = CW'(WIDTH - 1);

  logic [WIDTH-1:0] sh;
  logic [CW-1:0]    cnt;
  logic             out_q, done_q, lost_q;

  wire busy    = (cnt != '0);
  wire load_ok = load && !busy && !scl_rise;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh     <= '0;
      cnt    <= '0;
      out_q  <= 1'b1;
      done_q <= 1'b0;
      lost_q <= 1'b0;
    end else if (start) begin
      cnt    <= '0;
      done_q <= 1'b0;
      lost_q <= 1'b0;
    end else begin
      if (scl_fall)
        out_q <= lost_q ? 1'b1 : sh[WIDTH-1];
      if (scl_rise) begin
        sh     <= {sh[WIDTH-2:0], sda_in};
        cnt    <= (cnt == LAST) ? '0 : cnt + 1'b1;
        done_q <= (cnt == LAST);
        if (tx_mode && out_q && !sda_in)
          lost_q <= 1'b1;
      end else if (load_ok) begin
        sh     <= load_data;
        done_q <= 1'b0;
        lost_q <= 1'b0;
      end
    end
  end

  assign rd_data   = sh;
  assign sda_out   = out_q;
  assign byte_done = done_q;
  assign arb_lost  = lost_q;

  a_r3_out_moves_on_fall_only: assert property (@(posedge clk) disable iff (!rst_n)
    !scl_fall |=> $stable(sda_out));
  a_r4_shift_in_bus: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_rise && !start) |=> rd_data == {$past(rd_data[WIDTH-2:0]), $past(sda_in)});
  a_r5_done_after_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(byte_done) |-> $past(scl_rise));
  a_r6_load_ignored_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (load && busy && !start && !scl_rise) |=> $stable(rd_data));
  a_r7_start_keeps_data: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> ($stable(rd_data) && !byte_done && !arb_lost));
  a_r8_lost_detect: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_rise && tx_mode && sda_out && !sda_in && !start) |=> arb_lost);
  a_r8_release_after_loss: assert property (@(posedge clk) disable iff (!rst_n)
    (arb_lost && scl_fall && !start) |=> sda_out);
endmodule

// File: tb/i2c_byte_shifter_test.sv
module i2c_byte_shifter_test;
  logic clk = 0, rst_n = 0;
  logic load = 0, start = 0, scl_fall = 0, scl_rise = 0, sda_in = 1, tx_mode = 0;
  logic [7:0] load_data = 0;
  logic [7:0] rd_data;
  logic sda_out, byte_done, arb_lost;
  int checks = 0, fails = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  i2c_byte_shifter uut (.clk, .rst_n, .load, .load_data, .rd_data, .start, .scl_fall,
    .scl_rise, .sda_in, .tx_mode, .sda_out, .byte_done, .arb_lost);

  int m_sh = 0, m_cnt = 0;
  bit m_out = 1, m_done = 0, m_lost = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_sh = 0; m_cnt = 0; m_out = 1; m_done = 0; m_lost = 0;
    end else if (start) begin
      m_cnt = 0; m_done = 0; m_lost = 0;
    end else begin
      if (scl_fall) m_out = m_lost ? 1'b1 : bit'((m_sh / 128) % 2);
      if (scl_rise) begin
        if (tx_mode && m_out && !sda_in) m_lost = 1;
        m_sh = (m_sh * 2 + int'(sda_in)) % 256;
        m_cnt = m_cnt + 1;
        m_done = (m_cnt == 8);
        if (m_cnt == 8) m_cnt = 0;
      end else if (load && m_cnt == 0) begin
        m_sh = int'(load_data); m_done = 0; m_lost = 0;
      end
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n && !finished) begin
    check(rd_data == m_sh[7:0], "model rd_data (R4)", rd_data, m_sh);
    check(sda_out == m_out, "model sda_out (R3)", sda_out, m_out);
    check(byte_done == m_done, "model byte_done (R5)", byte_done, m_done);
    check(arb_lost == m_lost, "model arb_lost (R8)", arb_lost, m_lost);
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse_load(input logic [7:0] d);
    @(negedge clk) load = 1; load_data = d;
    @(negedge clk) load = 0;
  endtask

  task automatic pulse_start();
    @(negedge clk) start = 1;
    @(negedge clk) start = 0;
  endtask

  task automatic one_bit(input bit other);
    @(negedge clk) scl_fall = 1;
    @(negedge clk) scl_fall = 0; sda_in = sda_out & other; scl_rise = 1;
    @(negedge clk) scl_rise = 0; sda_in = 1;
  endtask

  task automatic byte_xfer(input logic [7:0] other);
    for (int b = 7; b >= 0; b--) one_bit(other[b]);
  endtask

  initial begin
    logic [7:0] keep;
    idle(2);
    check(rd_data == 8'h00 && sda_out && !byte_done && !arb_lost, "R1 reset", rd_data, 0);
    rst_n = 1;
    idle(1);

    pulse_load(8'hA5);
    check(rd_data == 8'hA5, "R2 idle load", rd_data, 8'hA5);

    tx_mode = 1;
    pulse_start();
    @(negedge clk) scl_fall = 1;
    @(negedge clk) scl_fall = 0;
    check(sda_out == 1'b1, "R3 first bit is bit 7 of A5", sda_out, 1);
    sda_in = 1; scl_rise = 1;
    @(negedge clk) scl_rise = 0;
    for (int b = 6; b >= 0; b--) one_bit(1'b1);
    check(byte_done == 1'b1, "R5 done after eight rises", byte_done, 1);
    check(rd_data == 8'hA5 && !arb_lost, "R9 echoed byte kept", rd_data, 8'hA5);
    one_bit(1'b1);
    check(byte_done == 1'b0, "R5 next rise clears done", byte_done, 0);

    pulse_start();
    pulse_load(8'h3C);
    @(negedge clk) scl_fall = 1;
    @(negedge clk) scl_fall = 0;
    check(sda_out == 1'b0, "R3 bit 7 of 3C driven", sda_out, 0);
    sda_in = 0; scl_rise = 1;
    @(negedge clk) scl_rise = 0; sda_in = 1;
    one_bit(1'b1); one_bit(1'b1);
    keep = rd_data;
    check(keep == 8'hE1, "R4 three bits shifted", keep, 8'hE1);
    pulse_load(8'hFF);
    check(rd_data == keep, "R6 load ignored mid-byte", rd_data, keep);
    pulse_start();
    check(rd_data == keep && !byte_done, "R7 start keeps data", rd_data, keep);
    pulse_load(8'hFF);
    check(rd_data == 8'hFF, "R2 load after start", rd_data, 8'hFF);

    tx_mode = 0;
    pulse_start();
    byte_xfer(8'h96);
    check(rd_data == 8'h96 && byte_done && !arb_lost, "R4 received byte", rd_data, 8'h96);

    tx_mode = 1;
    pulse_load(8'hF0);
    pulse_start();
    byte_xfer(8'hB7);
    check(arb_lost == 1'b1, "R8 arbitration lost", arb_lost, 1);
    check(sda_out == 1'b1, "R8 released after loss", sda_out, 1);
    check(rd_data == 8'hB7, "R9 bus byte after loss", rd_data, 8'hB7);
    pulse_load(8'h00);
    check(!arb_lost && rd_data == 8'h00, "R2 load clears lost", rd_data, 0);

    idle(2);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule